// File: doc/BRIEF.md
# Bus Transfer Sequencer

This block sits between the internal memory pipeline and the external system bus. It accepts one memory request at a time. Each request carries an address, a byte count, an operation, and cacheable and write-through attributes. From these the block picks the bus transaction to run:
- a single-beat sized transfer,
- a four-beat burst that moves a whole 32-byte block, or
- an address-only operation that has no data phase.

It then runs the address tenure. The tenure starts with a request/grant handshake with an external arbiter and ends when the address is acknowledged or retried.

Address and data tenures are decoupled. Once an address is acknowledged, its data tenure waits in a short in-order queue. The address side is then free to take the next request while earlier data is still moving. On the data side, a beat counter advances on every data acknowledge. The counter closes a tenure after one beat or after four beats. A retried address tenure re-arbitrates and re-issues the same address and type. Some address-only operations are broadcast only when a configuration bit permits; otherwise they are absorbed silently.

Top module: `bus_xfer_seq`

## Requirements
- R1: After reset `br_o`, `ts_o`, `dat_act_o`, `done_o` are low, `beat_o` is 0, and `req_ready_o` is high.
- R2: A read (`req_op_i`=0) with cacheable set, or a write (`req_op_i`=1) with cacheable set and write-through clear, runs as a burst. It has `tt_o`={0,write,1}, `tsiz_o`=0, an address whose low 5 bits are cleared, and a data tenure of exactly 4 beats.
- R3: Any other read or write runs as a single beat. It has `tt_o`={0,write,0}, `tsiz_o` equal to `req_size_i` (1, 2, 3, 4 or 8 bytes), the address unchanged, and a data tenure of 1 beat. A single-beat request never spans an 8-byte boundary.
- R4: An address-only request (`req_op_i`=2) runs an address tenure with `tt_o`=3'b100 and `tsiz_o`=0, and it never opens a data tenure.
- R5: An address-only request with `req_opt_bcast_i` set while `cfg_aonly_bcast_i` is low is accepted but produces no `br_o` and no `ts_o`.
- R6: `br_o` rises in the cycle after acceptance and stays high until `bg_i` is sampled. `ts_o` is a one-cycle pulse in the cycle after the grant, and it never occurs without a grant.
- R7: `addr_o`, `tt_o` and `tsiz_o` are held constant from the `ts_o` cycle until the address acknowledge.
- R8: `aack_i` with `artry_i` discards the tenure: no data tenure opens, `br_o` is high in the next cycle, and the re-issued `ts_o` carries the same address and type.
- R9: After an address acknowledge, a new request may be accepted while earlier data tenures are still open, up to 2 outstanding. `req_ready_o` is low while 2 data tenures are outstanding.
- R10: `beat_o` indexes the current beat (0..3), advances on `ta_i`, and returns to 0 after the last beat. `done_o` is high in exactly the cycle of the last `ta_i`. Data tenures complete in address order, with `dat_write_o` giving their direction.
- R11: `ta_i` while no data tenure is open has no effect on `beat_o`, `done_o` or `dat_act_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_aonly_bcast_i | input | 1 | Permits broadcast of optional address-only operations |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_addr_i | input | 32 | Request byte address |
| req_size_i | input | 4 | Byte count for single-beat transfers |
| req_op_i | input | 2 | 0 read, 1 write, 2 address-only |
| req_cacheable_i | input | 1 | Cacheable attribute |
| req_wt_i | input | 1 | Write-through attribute |
| req_opt_bcast_i | input | 1 | Address-only op whose broadcast is optional |
| br_o | output | 1 | Bus request to arbiter |
| bg_i | input | 1 | Bus grant |
| ts_o | output | 1 | Address tenure start strobe |
| addr_o | output | 32 | Address phase address |
| tt_o | output | 3 | Type: {address-only, write, burst} |
| tsiz_o | output | 4 | Byte count, 0 for burst or address-only |
| aack_i | input | 1 | Address acknowledge |
| artry_i | input | 1 | Address retry, sampled with aack_i |
| ta_i | input | 1 | Data beat acknowledge |
| dat_act_o | output | 1 | A data tenure is open |
| dat_write_o | output | 1 | Direction of the open data tenure |
| beat_o | output | 2 | Current beat index |
| done_o | output | 1 | Last beat of a data tenure acknowledged |

## Verification
A wrong classification shows up at once on `tt_o`, `tsiz_o` and `addr_o` in the `ts_o` cycle. It also shows up later as a wrong beat count before `done_o`. A stuck address state appears within a cycle as `br_o` or `ts_o` out of step with the grant and acknowledge. A corrupted data queue appears only when that tenure reaches the data side. It shows as a wrong `dat_write_o` direction, a premature or missing `done_o`, or `req_ready_o` failing to drop when two tenures are outstanding.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef struct packed {
    logic aonly;
    logic write;
    logic burst;
  } xtype_t;

  typedef enum logic [1:0] {A_IDLE, A_ARB, A_START, A_WAIT} astate_e;
endpackage

// File: rtl/xfer_classify.sv
module xfer_classify #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 32,
  parameter int SZ_W      = 4
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [1:0]      op_i,
  input  logic            cacheable_i,
  input  logic            wt_i,
  input  logic            opt_bcast_i,
  input  logic            cfg_bcast_i,
  output xfer_pkg::xtype_t type_o,
  output logic [AW-1:0]   addr_o,
  output logic [SZ_W-1:0] size_o,
  output logic            drop_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  logic aonly, wr, burst;

  always_comb begin
    aonly  = op_i[1];
    wr     = !aonly && op_i[0];
    burst  = !aonly && cacheable_i && !(wr && wt_i);
    type_o = '{aonly: aonly, write: wr, burst: burst};
    addr_o = burst ? {addr_i[AW-1:OFF_W], {OFF_W{1'b0}}} : addr_i;
    size_o = (burst || aonly) ? '0 : size_i;
    drop_o = aonly && opt_bcast_i && !cfg_bcast_i;
  end
endmodule

// File: rtl/addr_tenure.sv
module addr_tenure #(
  parameter int AW   = 32,
  parameter int SZ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             can_accept_i,
  input  logic             req_valid_i,
  input  logic             drop_i,
  input  xfer_pkg::xtype_t type_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic             req_ready_o,
  output logic             br_o,
  input  logic             bg_i,
  output logic             ts_o,
  output logic [AW-1:0]    addr_o,
  output logic [2:0]       tt_o,
  output logic [SZ_W-1:0]  tsiz_o,
  input  logic             aack_i,
  input  logic             artry_i,
  output logic             push_o,
  output xfer_pkg::xtype_t push_type_o
);
  import xfer_pkg::*;

  astate_e          state_q, state_d;
  xtype_t           type_q;
  logic [AW-1:0]    addr_q;
  logic [SZ_W-1:0]  size_q;
  logic             accept, drive;

  assign req_ready_o = (state_q == A_IDLE) && can_accept_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      A_IDLE:  if (accept && !drop_i) state_d = A_ARB;
      A_ARB:   if (bg_i) state_d = A_START;
      A_START: state_d = A_WAIT;
      A_WAIT:  if (aack_i) state_d = artry_i ? A_ARB : A_IDLE;
      default: state_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= A_IDLE;
      type_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        type_q <= type_i;
        addr_q <= addr_i;
        size_q <= size_i;
      end
    end
  end

  assign drive       = (state_q == A_START) || (state_q == A_WAIT);
  assign br_o        = (state_q == A_ARB);
  assign ts_o        = (state_q == A_START);
  assign addr_o      = drive ? addr_q : '0;
  assign tt_o        = drive ? type_q : '0;
  assign tsiz_o      = drive ? size_q : '0;
  assign push_o      = (state_q == A_WAIT) && aack_i && !artry_i && !type_q.aonly;
  assign push_type_o = type_q;

  assert_ts_after_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> $past(br_o && bg_i));
  assert_ts_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |=> !ts_o);
  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive && !ts_o) |-> ($stable(addr_o) && $stable(tt_o) && $stable(tsiz_o)));
  assert_retry_rearb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive && !ts_o && aack_i && artry_i) |=> (br_o && !ts_o));
endmodule

// File: rtl/data_tenure.sv
module data_tenure #(
  parameter int DEPTH = 2,
  parameter int BEATS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  xfer_pkg::xtype_t push_type_i,
  input  logic             ta_i,
  output logic             full_o,
  output logic             act_o,
  output logic             write_o,
  output logic [$clog2(BEATS)-1:0] beat_o,
  output logic             done_o
);
  localparam int BW = $clog2(BEATS);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] q_wr, q_bst;
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    beat_q;
  logic             head_bst, last, pop;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_wr[i]  <= 1'b0;
        q_bst[i] <= 1'b0;
      end else if (push_i && wr_q == PW'(i)) begin
        q_wr[i]  <= push_type_i.write;
        q_bst[i] <= push_type_i.burst;
      end
    end
  end

  assign act_o    = (cnt_q != '0);
  assign head_bst = q_bst[rd_q];
  assign write_o  = act_o && q_wr[rd_q];
  assign last     = !head_bst || (beat_q == BW'(BEATS - 1));
  assign pop      = act_o && ta_i && last;
  assign done_o   = pop;
  assign full_o   = (cnt_q == CW'(DEPTH));
  assign beat_o   = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      if (push_i) wr_q <= inc_ptr(wr_q);
      if (pop)    rd_q <= inc_ptr(rd_q);
      if (push_i && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push_i) cnt_q <= cnt_q - 1'b1;
      if (act_o && ta_i) beat_q <= last ? '0 : beat_q + 1'b1;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop));
  assert_single_beat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !head_bst) |-> (beat_o == '0));
  assert_done_rewind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (beat_o == '0));
  assert_ta_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && ta_i) |=> (beat_o == '0 && !done_o));
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq #(
  parameter int AW        = 32,
  parameter int SZ_W      = 4,
  parameter int BLK_BYTES = 32,
  parameter int BEATS     = 4,
  parameter int DQ_DEPTH  = 2,
  parameter int BUS_BYTES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_aonly_bcast_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [AW-1:0]            req_addr_i,
  input  logic [SZ_W-1:0]          req_size_i,
  input  logic [1:0]               req_op_i,
  input  logic                     req_cacheable_i,
  input  logic                     req_wt_i,
  input  logic                     req_opt_bcast_i,
  output logic                     br_o,
  input  logic                     bg_i,
  output logic                     ts_o,
  output logic [AW-1:0]            addr_o,
  output logic [2:0]               tt_o,
  output logic [SZ_W-1:0]          tsiz_o,
  input  logic                     aack_i,
  input  logic                     artry_i,
  input  logic                     ta_i,
  output logic                     dat_act_o,
  output logic                     dat_write_o,
  output logic [$clog2(BEATS)-1:0] beat_o,
  output logic                     done_o
);
  localparam int LANE_W = $clog2(BUS_BYTES);

  xfer_pkg::xtype_t c_type, push_type;
  logic [AW-1:0]    c_addr;
  logic [SZ_W-1:0]  c_size;
  logic             c_drop, push, q_full;

  xfer_classify #(.AW(AW), .BLK_BYTES(BLK_BYTES), .SZ_W(SZ_W)) u_cls (
    .addr_i      (req_addr_i),
    .size_i      (req_size_i),
    .op_i        (req_op_i),
    .cacheable_i (req_cacheable_i),
    .wt_i        (req_wt_i),
    .opt_bcast_i (req_opt_bcast_i),
    .cfg_bcast_i (cfg_aonly_bcast_i),
    .type_o      (c_type),
    .addr_o      (c_addr),
    .size_o      (c_size),
    .drop_o      (c_drop)
  );

  addr_tenure #(.AW(AW), .SZ_W(SZ_W)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .can_accept_i (!q_full),
    .req_valid_i  (req_valid_i),
    .drop_i       (c_drop),
    .type_i       (c_type),
    .addr_i       (c_addr),
    .size_i       (c_size),
    .req_ready_o  (req_ready_o),
    .br_o         (br_o),
    .bg_i         (bg_i),
    .ts_o         (ts_o),
    .addr_o       (addr_o),
    .tt_o         (tt_o),
    .tsiz_o       (tsiz_o),
    .aack_i       (aack_i),
    .artry_i      (artry_i),
    .push_o       (push),
    .push_type_o  (push_type)
  );

  data_tenure #(.DEPTH(DQ_DEPTH), .BEATS(BEATS)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_type_i (push_type),
    .ta_i        (ta_i),
    .full_o      (q_full),
    .act_o       (dat_act_o),
    .write_o     (dat_write_o),
    .beat_o      (beat_o),
    .done_o      (done_o)
  );

  // single-beat requests stay inside one bus-width lane group
  assert_lane_fit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !c_type.burst && !c_type.aonly) |->
    ((AW'(req_addr_i[LANE_W-1:0]) + AW'(req_size_i)) <= AW'(BUS_BYTES)));
  assert_suppress_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && c_drop) |=> (!br_o && !ts_o));
endmodule

// File: tb/bus_xfer_seq_test.sv
module bus_xfer_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bc = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [1:0]  req_op = '0;
  logic        req_c = 1'b0, req_wt = 1'b0, req_opt = 1'b0;
  logic        br, bg = 1'b0, ts;
  logic [31:0] addr;
  logic [2:0]  tt;
  logic [3:0]  tsiz;
  logic        aack = 1'b0, artry = 1'b0, ta = 1'b0;
  logic        dact, dwr, done;
  logic [1:0]  beat;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  bus_xfer_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_aonly_bcast_i(cfg_bc),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_op_i(req_op), .req_cacheable_i(req_c),
    .req_wt_i(req_wt), .req_opt_bcast_i(req_opt),
    .br_o(br), .bg_i(bg), .ts_o(ts), .addr_o(addr), .tt_o(tt), .tsiz_o(tsiz),
    .aack_i(aack), .artry_i(artry), .ta_i(ta),
    .dat_act_o(dact), .dat_write_o(dwr), .beat_o(beat), .done_o(done)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] s, input logic [1:0] op,
                       input logic c, input logic w, input logic opt);
    cmp("R9 ready before issue", 32'(req_ready), 1);
    req_addr = a; req_size = s; req_op = op; req_c = c; req_wt = w; req_opt = opt;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic addr_phase(input string tag, input logic [31:0] ea, input logic [2:0] ett,
                            input logic [3:0] esz, input logic retry);
    cmp("R6 br after accept", 32'(br), 1);
    cmp("R6 no ts before grant", 32'(ts), 0);
    bg = 1'b1;
    step();
    bg = 1'b0;
    cmp("R6 ts after grant", 32'(ts), 1);
    cmp({tag, " addr"}, addr, ea);
    cmp({tag, " tt"}, 32'(tt), 32'(ett));
    cmp({tag, " tsiz"}, 32'(tsiz), 32'(esz));
    step();
    cmp("R6 ts one cycle", 32'(ts), 0);
    cmp("R7 addr held", addr, ea);
    cmp("R7 tt held", 32'(tt), 32'(ett));
    aack = 1'b1; artry = retry;
    step();
    aack = 1'b0; artry = 1'b0;
  endtask

  task automatic data_phase(input string tag, input int beats, input logic wr);
    for (int i = 0; i < beats; i++) begin
      cmp({tag, " R10 act"}, 32'(dact), 1);
      cmp({tag, " R10 dir"}, 32'(dwr), 32'(wr));
      cmp({tag, " R10 beat"}, 32'(beat), 32'(i));
      ta = 1'b1;
      #1;
      cmp({tag, " R10 done"}, 32'(done), 32'(i == beats - 1));
      step();
      ta = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] sizes [5];
    int idx;
    sizes[0] = 1; sizes[1] = 2; sizes[2] = 3; sizes[3] = 4; sizes[4] = 8;
    repeat (3) step();
    // R1 reset state
    cmp("R1 br", 32'(br), 0);
    cmp("R1 ts", 32'(ts), 0);
    cmp("R1 dat_act", 32'(dact), 0);
    cmp("R1 beat", 32'(beat), 0);
    cmp("R1 ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    step();
    cmp("R1 done", 32'(done), 0);

    // sweep of op x cacheable x write-through x size (R2 R3 R4)
    idx = 0;
    for (int op = 0; op < 3; op++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++)
          for (int si = 0; si < 5; si++) begin
            logic [31:0] a, ea;
            logic [3:0]  s, es;
            logic        bst, wr_e, ao;
            s    = sizes[si];
            a    = 32'h1000_0000 + 32'(idx * 64) + 32'(8 * (idx % 4)) + 32'(idx % (9 - int'(s)));
            ao   = (op == 2);
            wr_e = (op == 1);
            bst  = !ao && (c == 1) && !(wr_e && (w == 1));
            ea   = bst ? (a & 32'hFFFF_FFE0) : a;
            es   = (bst || ao) ? 4'd0 : s;
            issue(a, s, 2'(op), c[0], w[0], 1'b0);
            addr_phase(ao ? "R4" : (bst ? "R2" : "R3"), ea, {ao, wr_e, bst}, es, 1'b0);
            if (ao) cmp("R4 no data tenure", 32'(dact), 0);
            else data_phase(bst ? "R2" : "R3", bst ? 4 : 1, wr_e);
            cmp("R10 queue drained", 32'(dact), 0);
            idx++;
          end

    // R5 suppressed optional broadcast
    cfg_bc = 1'b0;
    issue(32'h2000_0040, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1);
    cmp("R5 no br", 32'(br), 0);
    step();
    cmp("R5 no br later", 32'(br), 0);
    cmp("R5 no ts", 32'(ts), 0);
    cmp("R5 ready", 32'(req_ready), 1);
    // R4 non-optional address-only still broadcast with cfg low
    issue(32'h2000_0080, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    addr_phase("R4 cfg low", 32'h2000_0080, 3'b100, 4'd0, 1'b0);
    cmp("R4 no data", 32'(dact), 0);
    cfg_bc = 1'b1;

    // R6 grant withheld, R8 retry
    issue(32'h3000_0014, 4'd4, 2'd0, 1'b1, 1'b0, 1'b0);
    step(); step();
    cmp("R6 br held", 32'(br), 1);
    cmp("R6 no ts without grant", 32'(ts), 0);
    addr_phase("R8 first", 32'h3000_0000, 3'b001, 4'd0, 1'b1);
    cmp("R8 br reasserted", 32'(br), 1);
    cmp("R8 no data", 32'(dact), 0);
    addr_phase("R8 reissue", 32'h3000_0000, 3'b001, 4'd0, 1'b0);
    data_phase("R8", 4, 1'b0);

    // R9 decoupled tenures, queue full
    issue(32'h4000_0028, 4'd8, 2'd1, 1'b1, 1'b0, 1'b0);
    addr_phase("R9 A", 32'h4000_0020, 3'b011, 4'd0, 1'b0);
    issue(32'h4000_0106, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    addr_phase("R9 B", 32'h4000_0106, 3'b000, 4'd2, 1'b0);
    cmp("R9 ready low when full", 32'(req_ready), 0);
    data_phase("R9 A", 4, 1'b1);
    cmp("R9 ready after drain", 32'(req_ready), 1);
    data_phase("R9 B", 1, 1'b0);
    cmp("R9 empty", 32'(dact), 0);

    // R11 stray data acknowledge
    ta = 1'b1;
    #1;
    cmp("R11 no done", 32'(done), 0);
    step();
    ta = 1'b0;
    cmp("R11 beat", 32'(beat), 0);
    cmp("R11 act", 32'(dact), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule